// File: doc/BRIEF.md
# Closed Caption Line Insertion Controller

This block decides, line by line, whether the video encoder should replace the current line with a closed caption line. It also supplies the two payload bytes that the caption waveform generator serialises on that line. The video timing logic provides the current line number, the field identity, the 525/625 standard select and a one-cycle start-of-line strobe. A small register-side write port loads two holding bytes and a control byte. The control byte selects the field and a 4-bit line code, and it holds the parity-generation, enable and ready-to-send bits.

The holding bytes are double-buffered. On the start-of-line strobe of the selected line, the block copies them into a working payload register and clears the ready-to-send flag. Software may then load the next pair while the current line is still being sent. If no data is pending, the block sends null bytes with odd parity.

A three-state machine tracks the line:
- **ST_IDLE**: disabled.
- **ST_ARMED**: enabled and waiting for the selected line.
- **ST_SEND**: the current line is a caption line.

The transitions are:
- ST_IDLE to ST_ARMED when enable is set.
- ST_ARMED back to ST_IDLE when enable is cleared.
- Any state to ST_SEND on a strobe of a matching line.
- ST_SEND to ST_ARMED or ST_IDLE (according to enable) on a strobe of a line that does not match.

Top module: `cc_insert_ctrl`

## Requirements
- R1: No line is ever inserted while the enable bit (control bit 7) is low.
- R2: In 525-line mode (std_625 = 0), the selected line is the 4-bit line code (control bits 3:0) plus 12 on odd fields, or plus 274 on even fields.
- R3: In 625-line mode (std_625 = 1), the selected line is the line code plus 9 on odd fields, or plus 321 on even fields.
- R4: A line matches only when field_even equals the field select bit (control bit 4, where 1 means even).
- R5: If ready-to-send (control bit 6) is high at the strobe of the matching line, the two holding bytes become the payload.
- R6: If ready-to-send is low at that strobe, each payload byte is the null byte 0x80 (0x00 with odd parity), whatever the parity-enable bit is.
- R7: With parity enable (control bit 5) high, bit 7 of each sent data byte is replaced so that the byte has an odd number of ones.
- R8: With parity enable low, the 16 loaded bits are sent unchanged.
- R9: The transfer at the matching strobe clears ready-to-send, and ctrl_rdata bit 6 shows this from the next cycle.
- R10: A register write in the same cycle as a transfer lands after the transfer: the payload takes the old bytes, and the holding register keeps the new value.
- R11: ins_line rises in the cycle after the matching strobe and stays high until the next strobe. The payload bytes change only after a strobe, so consecutive lines can each carry fresh data.
- R12: setup_off is high whenever ins_line is high, so the setup pedestal is removed on caption lines.
- R13: The control state machine has the states ST_IDLE, ST_ARMED and ST_SEND. A disabled controller ends an ongoing caption line at the next strobe and inserts no further lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | 10 | Current line number |
| field_even | input | 1 | 1 during an even field |
| std_625 | input | 1 | 1 selects 625-line timing |
| sol | input | 1 | One-cycle start-of-line strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0: byte 0, 1: byte 1, 2: control, 3: unused |
| wr_data | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control byte readback {en, rts, par, fld, code[3:0]} |
| ins_line | output | 1 | Current line is a caption line |
| setup_off | output | 1 | Suppress setup pedestal on this line |
| cc_byte0 | output | 8 | First payload byte |
| cc_byte1 | output | 8 | Second payload byte |

## Verification
The hardest case to reach is a register write that lands in exactly the cycle the matching strobe moves the holding bytes into the payload. The strobe and the write must coincide on one clock edge. The bench's line driver can place a write in its strobe cycle, so a byte write collides with a transfer; a second transfer then shows that the new byte survived. Back-to-back caption lines are reached by rewriting the line code and ready-to-send bit while a line is in flight.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } cc_state_t;

    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_RTS_BIT = 6;
    localparam int CTL_PAR_BIT = 5;
    localparam int CTL_FLD_BIT = 4;

    localparam logic [1:0] ADDR_BYTE0 = 2'd0;
    localparam logic [1:0] ADDR_BYTE1 = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int NBYTES = 2;
endpackage

// File: rtl/cc_line_match.sv
module cc_line_match #(
    parameter int LINE_W   = 10,
    parameter int CODE_W   = 4,
    parameter int BASE_5O  = 12,
    parameter int BASE_5E  = 274,
    parameter int BASE_6O  = 9,
    parameter int BASE_6E  = 321
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_even,
    input  logic              std_625,
    input  logic              sel_even,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [LINE_W-1:0] base;
    logic [LINE_W-1:0] target;

    always_comb begin
        unique case ({std_625, sel_even})
            2'b00:   base = LINE_W'(BASE_5O);
            2'b01:   base = LINE_W'(BASE_5E);
            2'b10:   base = LINE_W'(BASE_6O);
            default: base = LINE_W'(BASE_6E);
        endcase
        target = base + LINE_W'(code);
        hit    = (field_even == sel_even) && (line_num == target);
    end
endmodule

// File: rtl/cc_parity_fix.sv
module cc_parity_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         par_en,
    input  logic         null_sel,
    output logic [W-1:0] dout
);
    always_comb begin
        if (null_sel)
            dout = {1'b1, {(W-1){1'b0}}};
        else if (par_en)
            dout = {~(^din[W-2:0]), din[W-2:0]};
        else
            dout = din;
    end
endmodule

// File: rtl/cc_insert_ctrl.sv
module cc_insert_ctrl
    import cc_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int CODE_W  = 4,
    parameter int BASE_5O = 12,
    parameter int BASE_5E = 274,
    parameter int BASE_6O = 9,
    parameter int BASE_6E = 321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_even,
    input  logic              std_625,
    input  logic              sol,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        ctrl_rdata,
    output logic              ins_line,
    output logic              setup_off,
    output logic [7:0]        cc_byte0,
    output logic [7:0]        cc_byte1
);
    cc_state_t state, state_nx;

    logic [NBYTES-1:0][7:0] hold_q;
    logic [NBYTES-1:0][7:0] pay_q;
    logic [NBYTES-1:0][7:0] pay_nx;
    logic [CODE_W-1:0]      code_q;
    logic                   fld_q, par_q, rts_q, en_q;
    logic                   hit;
    logic                   xfer;

    cc_line_match #(
        .LINE_W (LINE_W), .CODE_W (CODE_W),
        .BASE_5O(BASE_5O), .BASE_5E(BASE_5E),
        .BASE_6O(BASE_6O), .BASE_6E(BASE_6E)
    ) u_match (
        .line_num  (line_num),
        .field_even(field_even),
        .std_625   (std_625),
        .sel_even  (fld_q),
        .code      (code_q),
        .hit       (hit)
    );

    assign xfer = sol && en_q && hit;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        cc_parity_fix #(.W(8)) u_par (
            .din     (hold_q[b]),
            .par_en  (par_q),
            .null_sel(!rts_q),
            .dout    (pay_nx[b])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (xfer) begin
            state_nx = ST_SEND;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = en_q ? ST_ARMED : ST_IDLE;
                ST_ARMED: state_nx = en_q ? ST_ARMED : ST_IDLE;
                ST_SEND:  if (sol) state_nx = en_q ? ST_ARMED : ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // register file and working payload; a write in the transfer cycle lands last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pay_q  <= '0;
            code_q <= '0;
            fld_q  <= 1'b0;
            par_q  <= 1'b0;
            rts_q  <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (xfer) begin
                pay_q <= pay_nx;
                rts_q <= 1'b0;
            end
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_BYTE0: hold_q[0] <= wr_data;
                    ADDR_BYTE1: hold_q[1] <= wr_data;
                    ADDR_CTRL: begin
                        en_q   <= wr_data[CTL_EN_BIT];
                        rts_q  <= wr_data[CTL_RTS_BIT];
                        par_q  <= wr_data[CTL_PAR_BIT];
                        fld_q  <= wr_data[CTL_FLD_BIT];
                        code_q <= wr_data[CODE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        ins_line   = (state == ST_SEND);
        setup_off  = (state == ST_SEND);
        cc_byte0   = pay_q[0];
        cc_byte1   = pay_q[1];
        ctrl_rdata = {en_q, rts_q, par_q, fld_q, code_q};
    end
endmodule

// File: rtl/cc_insert_chk.sv
module cc_insert_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sol,
    input logic       wr_en,
    input logic [7:0] ctrl_rdata,
    input logic       ins_line,
    input logic       setup_off,
    input logic [7:0] cc_byte0,
    input logic [7:0] cc_byte1
);
    AST_INS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_line) |-> $past(ctrl_rdata[7])); // R1

    AST_INS_EDGE_AT_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ins_line) || $fell(ins_line)) |-> $past(sol)); // R11

    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sol |=> ($stable(cc_byte0) && $stable(cc_byte1))); // R11

    AST_RTS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_line && $past(sol) && !$past(wr_en)) |-> !ctrl_rdata[6]); // R9

    AST_NULL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_line && $past(sol) && !$past(ctrl_rdata[6]))
        |-> (cc_byte0 == 8'h80 && cc_byte1 == 8'h80)); // R6

    AST_SETUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ins_line |-> setup_off); // R12
endmodule

bind cc_insert_ctrl cc_insert_chk u_chk (.*);

// File: tb/tb_cc_insert_ctrl.sv
`timescale 1ns/1ps
module tb_cc_insert_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_num = '0;
    logic       field_even = 1'b0;
    logic       std_625 = 1'b0;
    logic       sol = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_rdata;
    logic       ins_line, setup_off;
    logic [7:0] cc_byte0, cc_byte1;

    int nchk = 0;
    int nerr = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cc_insert_ctrl dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected result, then plays one line
    task automatic run_line(input int ln, input bit fe, input bit s6,
                            input bit e_ins, input logic [7:0] e0, input logic [7:0] e1,
                            input string tag, input bit wr_same = 1'b0,
                            input logic [1:0] wa = 2'd0, input logic [7:0] wd = 8'h00);
        @(negedge clk);
        line_num = 10'(ln); field_even = fe; std_625 = s6;
        exp_q.push_back({e_ins, e0, e1});
        tag_q.push_back(tag);
        sol = 1'b1;
        if (wr_same) begin
            wr_en = 1'b1; wr_addr = wa; wr_data = wd;
        end
        @(negedge clk);
        sol = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R11 mid-line ins"}, 32'(ins_line), 32'(e_ins));
        chk({tag, " R12 setup_off"}, 32'(setup_off), 32'(e_ins));
    endtask

    // monitor: after each strobe, compare against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (sol && rst_n) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [16:0] it;
                    string t;
                    it = exp_q.pop_front();
                    t  = tag_q.pop_front();
                    chk({t, " ins"}, 32'(ins_line), 32'(it[16]));
                    if (it[16]) begin
                        chk({t, " byte0"}, 32'(cc_byte0), 32'(it[15:8]));
                        chk({t, " byte1"}, 32'(cc_byte1), 32'(it[7:0]));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset ins R11", 32'(ins_line), 0);
        chk("reset ctrl R9", 32'(ctrl_rdata), 0);
        chk("reset bytes R5", {cc_byte0, cc_byte1}, 0);

        // R1: disabled, rts set, line 21 odd 525
        reg_wr(2'd2, 8'h49);
        run_line(21, 0, 0, 0, 8'h00, 8'h00, "R1 disabled");

        // R2 R5 R8: code 9 -> line 21 on odd 525
        reg_wr(2'd0, 8'h14); reg_wr(2'd1, 8'h2C); reg_wr(2'd2, 8'hC9);
        run_line(20, 0, 0, 0, 8'h00, 8'h00, "R2 wrong line");
        run_line(21, 0, 0, 1, 8'h14, 8'h2C, "R2 R5 R8 data line");
        chk("R9 rts readback", 32'(ctrl_rdata), 32'h89);

        // R6: no rts -> null bytes, with and without parity enable
        run_line(22, 0, 0, 0, 8'h00, 8'h00, "R11 line ends");
        run_line(21, 0, 0, 1, 8'h80, 8'h80, "R6 null no par");
        reg_wr(2'd2, 8'hA9);
        run_line(21, 0, 0, 1, 8'h80, 8'h80, "R6 null par");

        // R7: parity generation
        reg_wr(2'd0, 8'h14); reg_wr(2'd1, 8'hFF); reg_wr(2'd2, 8'hE9);
        run_line(21, 0, 0, 1, 8'h94, 8'h7F, "R7 parity");

        // R4: field select even, code 0 -> line 274
        reg_wr(2'd0, 8'h01); reg_wr(2'd1, 8'h02); reg_wr(2'd2, 8'hD0);
        run_line(274, 0, 0, 0, 8'h00, 8'h00, "R4 wrong field");
        run_line(274, 1, 0, 1, 8'h01, 8'h02, "R4 R2 even field");

        // R3: 625 offsets
        reg_wr(2'd0, 8'h33); reg_wr(2'd1, 8'h44); reg_wr(2'd2, 8'hCF);
        run_line(27, 0, 1, 0, 8'h00, 8'h00, "R3 525 target on 625");
        run_line(24, 0, 1, 1, 8'h33, 8'h44, "R3 625 odd");
        reg_wr(2'd2, 8'hD0);
        run_line(321, 1, 1, 1, 8'h33, 8'h44, "R3 625 even");

        // R10: write collides with transfer
        reg_wr(2'd0, 8'h11); reg_wr(2'd1, 8'h22); reg_wr(2'd2, 8'hC9);
        run_line(21, 0, 0, 1, 8'h11, 8'h22, "R10 old payload", 1'b1, 2'd0, 8'h55);
        reg_wr(2'd2, 8'hC9);
        run_line(21, 0, 0, 1, 8'h55, 8'h22, "R10 new byte kept");

        // R11: consecutive lines with fresh data
        reg_wr(2'd0, 8'h0A); reg_wr(2'd1, 8'h0B); reg_wr(2'd2, 8'hC9);
        run_line(21, 0, 0, 1, 8'h0A, 8'h0B, "R11 line n");
        reg_wr(2'd0, 8'h0C); reg_wr(2'd2, 8'hCA);
        chk("R11 ins held across writes", 32'(ins_line), 1);
        run_line(22, 0, 0, 1, 8'h0C, 8'h0B, "R11 line n+1");

        // R13: disable during a caption line
        reg_wr(2'd2, 8'h0B);
        chk("R13 line continues", 32'(ins_line), 1);
        run_line(23, 0, 0, 0, 8'h00, 8'h00, "R13 idle after disable");
        run_line(23, 0, 0, 0, 8'h00, 8'h00, "R13 stays idle");
        chk("R13 ctrl readback", 32'(ctrl_rdata), 32'h0B);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule